// File: doc/BRIEF.md
# Processor Status and Width Control

This block keeps the eight-bit status word and the hidden emulation bit of a 16-bit processor core that grew out of an 8-bit one. Each cycle it takes at most one command strobe and changes the flags to match. The commands are: OR a mask into the status byte, clear the bits a mask selects, set or clear a single flag, swap carry with the emulation bit, load the whole byte from a stack read, or take new arithmetic flags from the ALU. It also tells the rest of the core the current accumulator width and index width. When the index registers narrow to 8 bits, it raises a strobe so that their high bytes get cleared.

Status bits, from bit 0 up: carry, zero, interrupt disable, decimal, index width (also read as break in emulation), accumulator/memory width, overflow, negative. In native mode a width bit of 1 selects 8 bits and 0 selects 16 bits. In emulation mode both width bits are held at 1, and both widths are 8 bits.

Top module: `status_width_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, status is 0x34 (interrupt disable and both width bits set, all others clear), emu_mode is 1, acc_8bit and idx_8bit are 1, and idx_hi_clear is 0.
- R2: The set-mask command (cmd bit 0) ORs operand into status on the next clock edge.
- R3: The clear-mask command (cmd bit 1) clears each status bit whose operand bit is 1. In emulation mode, bits 5 and 4 stay 1.
- R4: Single-flag commands take effect on the next edge. Clear carry is cmd bit 2 and acts on status bit 0. Clear interrupt disable is cmd bit 3 and acts on bit 2. Clear decimal is cmd bit 4 and acts on bit 3. Clear overflow is cmd bit 5 and acts on bit 6. Set carry is cmd bit 6. Set decimal is cmd bit 7. Set interrupt disable is cmd bit 8.
- R5: The exchange command (cmd bit 9) loads emu_mode with the old carry and loads carry with the old emu_mode, both in one edge.
- R6: Whenever emu_mode is 1, status bits 5 and 4 read 1, and acc_8bit and idx_8bit are 1, whatever command came before.
- R7: In native mode, acc_8bit equals status bit 5 and idx_8bit equals status bit 4.
- R8: The pull command (cmd bit 10) loads status from pull_byte, except that bits 5 and 4 are forced to 1 in emulation mode.
- R9: The ALU update command (cmd bit 11) copies alu_flags into status for each flag whose alu_we bit is 1. Bit 0 is carry, bit 1 is zero, bit 2 is overflow and bit 3 is negative. Flags whose enable is 0 keep their values.
- R10: idx_hi_clear is 1 for exactly the one cycle in which idx_8bit goes from 0 to 1, whether a mask, pull or exchange command caused the change.
- R11: A cmd with more than one bit set, or with no bit set, changes neither status nor emu_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 12 | One-hot command strobes (bit map in R2 to R11) |
| operand | input | 8 | Mask for the set-mask and clear-mask commands |
| alu_we | input | 4 | Per-flag enables for the ALU update |
| alu_flags | input | 4 | Flag values from the ALU: carry, zero, overflow, negative |
| pull_byte | input | 8 | Status byte read back from the stack |
| status | output | 8 | Current status byte |
| emu_mode | output | 1 | Emulation mode bit |
| acc_8bit | output | 1 | Accumulator/memory width is 8 bits |
| idx_8bit | output | 1 | Index register width is 8 bits |
| idx_hi_clear | output | 1 | One-cycle strobe to clear the index high bytes |

## Verification
The hardest state to reach is leaving emulation with carry at 0 and then entering it again. The exchange command must be made to carry a real 0 or 1 in each direction, and the re-entry must overwrite width bits that were cleared in native mode. The stimulus table first swaps out of emulation and clears both width bits. It then pulls a byte with carry set and swaps back in, and checks that bits 5 and 4 return to 1 while the old emulation bit lands in carry. A directed test then reaches idx_hi_clear three ways: through a mask, through a pull followed by an exchange, and with no change at all.

// File: rtl/status_width_ctrl.sv
module status_width_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] cmd,
  input  logic [7:0]  operand,
  input  logic [3:0]  alu_we,
  input  logic [3:0]  alu_flags,
  input  logic [7:0]  pull_byte,
  output logic [7:0]  status,
  output logic        emu_mode,
  output logic        acc_8bit,
  output logic        idx_8bit,
  output logic        idx_hi_clear
);
  localparam int C_SETM = 0, C_CLRM = 1, C_CLC = 2, C_CLI = 3, C_CLD = 4, C_CLV = 5;
  localparam int C_SEC = 6, C_SED = 7, C_SEI = 8, C_XCH = 9, C_PULL = 10, C_ALU = 11;
  localparam int B_C = 0, B_Z = 1, B_I = 2, B_D = 3, B_X = 4, B_M = 5, B_V = 6, B_N = 7;
  localparam logic [7:0] RESET_P = 8'h34;

  logic [7:0] p_q, p_d;
  logic       e_q, e_d;
  logic       clr_q;
  logic       legal;
  logic       idx_next;

  assign legal = (cmd != '0) && ((cmd & (cmd - 12'd1)) == '0);

  always_comb begin
    p_d = p_q;
    e_d = e_q;
    if (legal) begin
      if (cmd[C_SETM]) p_d = p_q | operand;
      if (cmd[C_CLRM]) p_d = p_q & ~operand;
      if (cmd[C_CLC])  p_d[B_C] = 1'b0;
      if (cmd[C_CLI])  p_d[B_I] = 1'b0;
      if (cmd[C_CLD])  p_d[B_D] = 1'b0;
      if (cmd[C_CLV])  p_d[B_V] = 1'b0;
      if (cmd[C_SEC])  p_d[B_C] = 1'b1;
      if (cmd[C_SED])  p_d[B_D] = 1'b1;
      if (cmd[C_SEI])  p_d[B_I] = 1'b1;
      if (cmd[C_XCH]) begin
        e_d      = p_q[B_C];
        p_d[B_C] = e_q;
      end
      if (cmd[C_PULL]) p_d = pull_byte;
      if (cmd[C_ALU]) begin
        if (alu_we[0]) p_d[B_C] = alu_flags[0];
        if (alu_we[1]) p_d[B_Z] = alu_flags[1];
        if (alu_we[2]) p_d[B_V] = alu_flags[2];
        if (alu_we[3]) p_d[B_N] = alu_flags[3];
      end
    end
    if (e_d) p_d[B_M:B_X] = 2'b11;
  end

  assign idx_next = e_d | p_d[B_X];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_q   <= RESET_P;
      e_q   <= 1'b1;
      clr_q <= 1'b0;
    end else begin
      p_q   <= p_d;
      e_q   <= e_d;
      clr_q <= idx_next & ~idx_8bit;
    end
  end

  assign status       = p_q;
  assign emu_mode     = e_q;
  assign acc_8bit     = e_q | p_q[B_M];
  assign idx_8bit     = e_q | p_q[B_X];
  assign idx_hi_clear = clr_q;
endmodule

module status_width_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] cmd,
  input logic [7:0]  operand,
  input logic [7:0]  status,
  input logic        emu_mode,
  input logic        acc_8bit,
  input logic        idx_8bit,
  input logic        idx_hi_clear
);
  // R6
  emu_forces_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |-> (acc_8bit && idx_8bit && status[5:4] == 2'b11));

  // R5
  exchange_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 12'h200) |=> (emu_mode == $past(status[0]) && status[0] == $past(emu_mode)));

  // R2
  set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 12'h001) |=> ((status & $past(operand)) == $past(operand)));

  // R3
  clr_mask_native_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 12'h002 && !emu_mode) |=> ((status & $past(operand)) == 8'h00));

  // R11
  illegal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cmd) != 1) |=> ($stable(status) && $stable(emu_mode)));

  // R10
  idx_clear_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_hi_clear |-> (idx_8bit && !$past(idx_8bit)));
endmodule

bind status_width_ctrl status_width_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .operand(operand), .status(status),
  .emu_mode(emu_mode), .acc_8bit(acc_8bit), .idx_8bit(idx_8bit),
  .idx_hi_clear(idx_hi_clear)
);

// File: tb/status_width_ctrl_test.sv
module status_width_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cmd = '0;
  logic [7:0]  operand = '0;
  logic [3:0]  alu_we = '0;
  logic [3:0]  alu_flags = '0;
  logic [7:0]  pull_byte = '0;
  logic [7:0]  status;
  logic        emu_mode, acc_8bit, idx_8bit, idx_hi_clear;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  status_width_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .operand(operand), .alu_we(alu_we),
    .alu_flags(alu_flags), .pull_byte(pull_byte), .status(status),
    .emu_mode(emu_mode), .acc_8bit(acc_8bit), .idx_8bit(idx_8bit),
    .idx_hi_clear(idx_hi_clear)
  );

  // {cmd, operand, alu_we, alu_flags, pull_byte, expected status, expected emu}
  localparam int NV = 20;
  localparam logic [44:0] VEC [NV] = '{
    {12'h200, 8'h00, 4'h0, 4'h0, 8'h00, 8'h35, 1'b0}, // R5 leave emulation, carry<-1
    {12'h002, 8'h30, 4'h0, 4'h0, 8'h00, 8'h05, 1'b0}, // R3 R7 both widths to 16
    {12'h001, 8'h10, 4'h0, 4'h0, 8'h00, 8'h15, 1'b0}, // R2
    {12'h080, 8'h00, 4'h0, 4'h0, 8'h00, 8'h1D, 1'b0}, // R4 set decimal
    {12'h010, 8'h00, 4'h0, 4'h0, 8'h00, 8'h15, 1'b0}, // R4 clear decimal
    {12'h001, 8'h40, 4'h0, 4'h0, 8'h00, 8'h55, 1'b0}, // R2
    {12'h020, 8'h00, 4'h0, 4'h0, 8'h00, 8'h15, 1'b0}, // R4 clear overflow
    {12'h008, 8'h00, 4'h0, 4'h0, 8'h00, 8'h11, 1'b0}, // R4 clear int disable
    {12'h100, 8'h00, 4'h0, 4'h0, 8'h00, 8'h15, 1'b0}, // R4 set int disable
    {12'h004, 8'h00, 4'h0, 4'h0, 8'h00, 8'h14, 1'b0}, // R4 clear carry
    {12'h800, 8'h00, 4'hF, 4'hA, 8'h00, 8'h96, 1'b0}, // R9 all flags
    {12'h800, 8'h00, 4'h1, 4'h1, 8'h00, 8'h97, 1'b0}, // R9 carry only
    {12'h800, 8'h00, 4'h8, 4'h0, 8'h00, 8'h17, 1'b0}, // R9 negative only
    {12'h003, 8'hFF, 4'h0, 4'h0, 8'h00, 8'h17, 1'b0}, // R11 two bits
    {12'h000, 8'hFF, 4'hF, 4'hF, 8'hFF, 8'h17, 1'b0}, // R11 no bits
    {12'h400, 8'h00, 4'h0, 4'h0, 8'hC3, 8'hC3, 1'b0}, // R8 native pull
    {12'h200, 8'h00, 4'h0, 4'h0, 8'h00, 8'hF2, 1'b1}, // R5 R6 re-enter emulation
    {12'h002, 8'hFF, 4'h0, 4'h0, 8'h00, 8'h30, 1'b1}, // R3 R6 widths held
    {12'h400, 8'h00, 4'h0, 4'h0, 8'h00, 8'h30, 1'b1}, // R8 emulation pull
    {12'h200, 8'h00, 4'h0, 4'h0, 8'h00, 8'h31, 1'b0}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [11:0] c, input logic [7:0] op, input logic [3:0] we,
                      input logic [3:0] fl, input logic [7:0] pb);
    @(negedge clk);
    cmd = c; operand = op; alu_we = we; alu_flags = fl; pull_byte = pb;
    @(posedge clk);
    #1;
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " status"}, {24'h0, status}, 32'h34);
    check({tag, " emu/widths/strobe"}, {28'h0, emu_mode, acc_8bit, idx_8bit, idx_hi_clear}, 32'hE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset_state("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_reset_state("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      logic [7:0] es;
      logic ee;
      v = VEC[i];
      es = v[8:1];
      ee = v[0];
      step(v[44:33], v[32:25], v[24:21], v[20:17], v[16:9]);
      check($sformatf("R2-R11 vector %0d status", i), {24'h0, status}, {24'h0, es});
      check($sformatf("R6 R7 vector %0d emu/acc/idx", i), {29'h0, emu_mode, acc_8bit, idx_8bit},
            {29'h0, ee, ee | es[5], ee | es[4]});
    end

    // R10 strobe through the masks
    step(12'h002, 8'h10, 4'h0, 4'h0, 8'h00);
    check("R10 narrow->wide no strobe", {30'h0, idx_8bit, idx_hi_clear}, 32'h0);
    step(12'h001, 8'h10, 4'h0, 4'h0, 8'h00);
    check("R10 strobe on set-mask", {30'h0, idx_8bit, idx_hi_clear}, 32'h3);
    step(12'h000, 8'h00, 4'h0, 4'h0, 8'h00);
    check("R10 strobe one cycle", {30'h0, idx_8bit, idx_hi_clear}, 32'h2);
    step(12'h001, 8'h10, 4'h0, 4'h0, 8'h00);
    check("R10 no strobe when already 8-bit", {31'h0, idx_hi_clear}, 32'h0);
    // R10 strobe through the exchange into emulation
    step(12'h400, 8'h00, 4'h0, 4'h0, 8'h01);
    check("R8 pull native", {23'h0, status, emu_mode}, {23'h0, 8'h01, 1'b0});
    check("R10 pull widening", {30'h0, idx_8bit, idx_hi_clear}, 32'h0);
    step(12'h200, 8'h00, 4'h0, 4'h0, 8'h00);
    check("R5 R10 exchange into emulation", {22'h0, status, emu_mode, idx_hi_clear},
          {22'h0, 8'h30, 1'b1, 1'b1});

    // R1 mid-run reset
    step(12'h080, 8'h00, 4'h0, 4'h0, 8'h00);
    @(negedge clk);
    cmd = '0;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check_reset_state("R1 mid-run reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule